// File: doc/BRIEF.md
# VC-Merge Output Reassembly Queue

This block is the output-port stage of a cell switch in which several incoming virtual circuits share one outgoing circuit label. Every cell arrives with a tag that names its destination output port, its input port, a VC index local to that input port, and an end-of-packet flag. The input port and the VC index together select one of the block's reassembly queues. A cell stays in its reassembly queue until the cell that ends its packet arrives. Cells are never forwarded before that point.

When the end-of-packet cell is accepted, the whole packet is spliced in one step onto a single output FIFO. The cells then leave back to back, in arrival order, on a valid/ready stream. Each leaving cell carries an outgoing label taken from a translation table, and several queues may map to the same label. All queues share one pool of cell slots, kept as linked lists with a per-slot state.

The input side has no back-pressure. When the pool is full, an arriving cell is dropped and the rest of its packet is discarded. The output side obeys valid/ready: a cell is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field is held.

Top module: `vcm_reasm`

## Requirements
- R1: After reset `out_valid` is 0 and both `drop_cnt` and `pkt_cnt` are 0.
- R2: A cell whose `in_oport` differs from parameter `PORT_ID` (default 1) is ignored. It produces no output and does not change `drop_cnt`.
- R3: Queue index is `in_iport*VC_PER_IN + in_vc`. Cells without `in_eop` are held, and `out_valid` stays 0 while only unfinished packets are buffered.
- R4: A completed packet is emitted as an unbroken run of cells in arrival order. `out_eop` is 1 on its last cell only, and no cell of another packet appears inside the run.
- R5: `out_label` equals the `LBL_W`-bit field `q` of `LABEL_MAP`, field 0 in the least significant bits. By default queues 0 and 2 map to 0x11, and queues 1 and 3 map to 0x22.
- R6: Packets leave in the order in which their end-of-packet cells were accepted, whichever packet started first.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_label` and `out_eop` do not change.
- R8: A cell is dropped and `drop_cnt` rises by one in two cases: when all `CELLS` slots are in use, or when its queue is discarding. A drop frees the queue's unfinished cells, and the queue then discards through its next end-of-packet cell, that cell included. Other queues' packets are unaffected.
- R9: `pkt_cnt` rises by one for each transferred cell with `out_eop` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A tagged cell is present |
| in_oport | input | PORT_W | Destination output port of the cell |
| in_iport | input | clog2(NUM_IN) | Input port the cell came from |
| in_vc | input | clog2(VC_PER_IN) | Incoming VC index within that input port |
| in_eop | input | 1 | Cell is the last of its packet |
| in_data | input | DATA_W | Cell payload word |
| out_valid | output | 1 | Output cell available |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_data | output | DATA_W | Output payload word |
| out_label | output | LBL_W | Translated outgoing VC label |
| out_eop | output | 1 | Output cell ends its packet |
| drop_cnt | output | CNT_W | Cells dropped, wrapping |
| pkt_cnt | output | CNT_W | Packets forwarded, wrapping |

## Verification
Single packets whose cells are spaced by idle gaps show whether the block holds cells until end-of-packet or forwards them early. Interleaved arrivals on two queues that share one outgoing label, with completions in the opposite order to their starts, separate true packet atomicity and completion order from plain arrival order. A toggling `out_ready` tests hold behaviour in the middle of a packet. A pool filled with the output stalled tests the three drop paths (full, discarding, discard-ending end-of-packet) and shows that a completed packet from another queue survives.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [1:0] {
    CELL_FREE = 2'd0,
    CELL_PART = 2'd1,
    CELL_OUT  = 2'd2
  } cell_st_e;
endpackage

// File: rtl/vcm_alloc.sv
module vcm_alloc #(
  parameter int CELLS = 8,
  localparam int PTR_W = $clog2(CELLS)
) (
  input  logic [CELLS-1:0] free_vec,
  output logic             any_free,
  output logic [PTR_W-1:0] pick
);
  // lowest-numbered free slot wins
  always_comb begin
    pick = '0;
    for (int i = CELLS - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = PTR_W'(i);
    end
  end
  assign any_free = |free_vec;
endmodule

// File: rtl/vcm_xlate.sv
module vcm_xlate #(
  parameter int NQ = 4,
  parameter int LBL_W = 8,
  parameter logic [NQ*LBL_W-1:0] LABEL_MAP = '0,
  localparam int Q_W = $clog2(NQ)
) (
  input  logic [Q_W-1:0]   q_idx,
  output logic [LBL_W-1:0] label
);
  assign label = LABEL_MAP[q_idx*LBL_W +: LBL_W];
endmodule

// File: rtl/vcm_reasm.sv
module vcm_reasm
  import vcm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_IN    = 2,
  parameter int VC_PER_IN = 2,
  parameter int CELLS     = 8,
  parameter int LBL_W     = 8,
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 16,
  parameter int PORT_ID   = 1,
  parameter logic [NUM_IN*VC_PER_IN*LBL_W-1:0] LABEL_MAP = 32'h2211_2211,
  localparam int NQ     = NUM_IN * VC_PER_IN,
  localparam int IP_W   = $clog2(NUM_IN),
  localparam int VC_W   = $clog2(VC_PER_IN),
  localparam int Q_W    = $clog2(NQ),
  localparam int PTR_W  = $clog2(CELLS),
  localparam int OCNT_W = $clog2(CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_oport,
  input  logic [IP_W-1:0]   in_iport,
  input  logic [VC_W-1:0]   in_vc,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LBL_W-1:0]  out_label,
  output logic              out_eop,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  pkt_cnt
);
  // shared cell pool
  cell_st_e          cst  [CELLS];
  logic [Q_W-1:0]    cown [CELLS];
  logic              ceop [CELLS];
  logic [DATA_W-1:0] cdat [CELLS];
  logic [PTR_W-1:0]  cnxt [CELLS];
  logic [CELLS-1:0]  free_vec;

  // per-queue unfinished packet lists
  logic [PTR_W-1:0]  phead [NQ];
  logic [PTR_W-1:0]  ptail [NQ];
  logic [OCNT_W-1:0] pcnt  [NQ];
  logic [NQ-1:0]     disc;

  // output FIFO list
  logic [PTR_W-1:0]  ohead, otail;
  logic [OCNT_W-1:0] ocnt, ocnt_nxt;

  logic [Q_W-1:0]    q;
  logic              for_me, any_free, accept, drop, splice, pop;
  logic [PTR_W-1:0]  fidx, ph;
  logic [OCNT_W-1:0] plen;

  for (genvar g = 0; g < CELLS; g++) begin : g_free
    assign free_vec[g] = (cst[g] == CELL_FREE);
  end

  vcm_alloc #(.CELLS(CELLS)) u_alloc (
    .free_vec(free_vec), .any_free(any_free), .pick(fidx)
  );

  vcm_xlate #(.NQ(NQ), .LBL_W(LBL_W), .LABEL_MAP(LABEL_MAP)) u_xlate (
    .q_idx(cown[ohead]), .label(out_label)
  );

  assign q      = Q_W'(in_iport) * Q_W'(VC_PER_IN) + Q_W'(in_vc);
  assign for_me = in_valid && (in_oport == PORT_W'(PORT_ID));
  assign accept = for_me && !disc[q] && any_free;
  assign drop   = for_me && !accept;
  assign splice = accept && in_eop;
  assign ph     = (pcnt[q] == '0) ? fidx : phead[q];
  assign plen   = pcnt[q] + OCNT_W'(1);

  assign out_valid = (ocnt != '0);
  assign out_data  = cdat[ohead];
  assign out_eop   = ceop[ohead];
  assign pop       = out_valid && out_ready;

  always_comb begin
    ocnt_nxt = ocnt;
    if (splice) ocnt_nxt = ocnt_nxt + plen;
    if (pop)    ocnt_nxt = ocnt_nxt - OCNT_W'(1);
  end

  // payload and link storage (no reset)
  always_ff @(posedge clk) begin
    if (accept) begin
      cdat[fidx] <= in_data;
      cown[fidx] <= q;
      ceop[fidx] <= in_eop;
      if (pcnt[q] != '0) cnxt[ptail[q]] <= fidx;
    end
    if (splice && ocnt != '0) cnxt[otail] <= ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) cst[i] <= CELL_FREE;
      for (int j = 0; j < NQ; j++) begin
        phead[j] <= '0;
        ptail[j] <= '0;
        pcnt[j]  <= '0;
      end
      disc     <= '0;
      ohead    <= '0;
      otail    <= '0;
      ocnt     <= '0;
      drop_cnt <= '0;
      pkt_cnt  <= '0;
    end else begin
      for (int i = 0; i < CELLS; i++) begin
        if (pop && ohead == PTR_W'(i)) begin
          cst[i] <= CELL_FREE;
        end else if (cst[i] == CELL_PART && cown[i] == q) begin
          if (splice)    cst[i] <= CELL_OUT;
          else if (drop) cst[i] <= CELL_FREE;
        end
        if (accept && fidx == PTR_W'(i)) cst[i] <= in_eop ? CELL_OUT : CELL_PART;
      end

      if (accept) begin
        if (in_eop) begin
          pcnt[q] <= '0;
        end else begin
          if (pcnt[q] == '0) phead[q] <= fidx;
          ptail[q] <= fidx;
          pcnt[q]  <= plen;
        end
      end
      if (drop) begin
        pcnt[q]  <= '0;
        disc[q]  <= !in_eop;
        drop_cnt <= drop_cnt + CNT_W'(1);
      end

      if (pop && (!splice || ocnt != OCNT_W'(1))) ohead <= cnxt[ohead];
      if (splice) begin
        if (ocnt == '0 || (pop && ocnt == OCNT_W'(1))) ohead <= ph;
        otail <= fidx;
      end
      ocnt <= ocnt_nxt;
      if (pop && out_eop) pkt_cnt <= pkt_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vcm_reasm_chk.sv
module vcm_reasm_chk #(
  parameter int DATA_W  = 16,
  parameter int LBL_W   = 8,
  parameter int PORT_W  = 2,
  parameter int CNT_W   = 16,
  parameter int PORT_ID = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PORT_W-1:0] in_oport,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [LBL_W-1:0]  out_label,
  input logic              out_eop,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic [CNT_W-1:0]  pkt_cnt
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_label) && $stable(out_eop)); // R7

  AST_PKT_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop |=> out_valid && out_label == $past(out_label)); // R4

  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_oport != PORT_W'(PORT_ID) |=> $stable(drop_cnt)); // R2

  AST_PKT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> pkt_cnt == $past(pkt_cnt) + CNT_W'(1)); // R9

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(drop_cnt)); // R8
endmodule

bind vcm_reasm vcm_reasm_chk #(
  .DATA_W(DATA_W), .LBL_W(LBL_W), .PORT_W(PORT_W), .CNT_W(CNT_W), .PORT_ID(PORT_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_oport(in_oport),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_label(out_label), .out_eop(out_eop), .drop_cnt(drop_cnt), .pkt_cnt(pkt_cnt)
);

// File: tb/vcm_reasm_tb.sv
`timescale 1ns/1ps
module vcm_reasm_tb;
  localparam int CELLS = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [1:0]  in_oport = 0;
  logic        in_iport = 0;
  logic        in_vc = 0;
  logic        in_eop = 0;
  logic [15:0] in_data = 0;
  logic        out_valid, out_eop;
  logic        out_ready = 0;
  logic [15:0] out_data;
  logic [7:0]  out_label;
  logic [15:0] drop_cnt, pkt_cnt;

  always #2 clk = ~clk;

  vcm_reasm u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_oport(in_oport),
    .in_iport(in_iport), .in_vc(in_vc), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_label(out_label), .out_eop(out_eop), .drop_cnt(drop_cnt), .pkt_cnt(pkt_cnt)
  );

  typedef struct packed {
    logic [15:0] d;
    logic [7:0]  l;
    logic        e;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] pend[4][$];
  bit          disc_m[4];
  int          occ = 0, drops_m = 0, pkts_m = 0;
  int          checks = 0, errors = 0;
  bit          toggle_en = 0;
  int          cyc = 0;

  function automatic logic [7:0] lbl_of(int q);
    return (q % 2 == 0) ? 8'h11 : 8'h22; // R5 default map
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  // driver: called at posedge+1, leaves at posedge+1 with in_valid low
  task automatic send_cell(int q, logic [15:0] d, bit eop, int oport = 1);
    in_oport = oport[1:0];
    in_iport = q[1];
    in_vc    = q[0];
    in_eop   = eop;
    in_data  = d;
    in_valid = 1;
    if (oport == 1) begin
      if (disc_m[q]) begin
        drops_m++;
        if (eop) disc_m[q] = 0;
      end else if (occ >= CELLS) begin
        drops_m++;
        occ -= pend[q].size();
        pend[q].delete();
        disc_m[q] = !eop;
      end else begin
        pend[q].push_back(d);
        occ++;
        if (eop) begin
          for (int i = 0; i < pend[q].size(); i++)
            exp_q.push_back('{d: pend[q][i], l: lbl_of(q), e: (i == pend[q].size() - 1)});
          pend[q].delete();
        end
      end
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain(bit tog);
    toggle_en = tog;
    if (!tog) out_ready = 1;
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) idle(1);
    toggle_en = 0;
    out_ready = 1;
    idle(2);
    check(exp_q.size() == 0, "R4", "scoreboard not drained", exp_q.size(), 0);
  endtask

  always begin
    @(posedge clk); #1;
    cyc++;
    if (toggle_en) out_ready = (cyc % 4) != 0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    item_t e;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R4", "unexpected output cell", out_data, 0);
      end else begin
        e = exp_q.pop_front();
        check(out_data == e.d, "R4", "data/order", out_data, e.d);
        check(out_label == e.l, "R5", "label", out_label, e.l);
        check(out_eop == e.e, "R4", "eop flag", out_eop, e.e);
        occ--;
        if (out_eop) pkts_m++;
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] held, d0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(posedge clk); #1;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(drop_cnt == 0, "R1", "drop_cnt after reset", drop_cnt, 0);
    check(pkt_cnt == 0, "R1", "pkt_cnt after reset", pkt_cnt, 0);
    @(posedge clk); #1;

    // R3: held until end-of-packet
    out_ready = 1;
    send_cell(1, 16'h0101, 0);
    idle(2);
    send_cell(1, 16'h0102, 0);
    idle(3);
    @(negedge clk);
    check(out_valid == 0, "R3", "early output before eop", out_valid, 0);
    @(posedge clk); #1;
    send_cell(1, 16'h0103, 1);
    drain(0);

    // R2: foreign output port ignored
    d0 = drop_cnt;
    send_cell(2, 16'h0E0E, 1, 2);
    idle(2);
    @(negedge clk);
    check(out_valid == 0, "R2", "foreign cell emitted", out_valid, 0);
    check(drop_cnt == d0, "R2", "foreign cell counted", drop_cnt, d0);
    @(posedge clk); #1;

    // R6: completion order, R7: hold under back-pressure
    out_ready = 0;
    send_cell(0, 16'h0A01, 0);
    send_cell(3, 16'h0B01, 0);
    send_cell(3, 16'h0B02, 1);
    send_cell(0, 16'h0A02, 1);
    @(negedge clk);
    check(out_valid == 1 && out_data == 16'h0B01, "R6", "first completed packet first", out_data, 16'h0B01);
    held = out_data;
    @(posedge clk); #1;
    idle(3);
    @(negedge clk);
    check(out_valid == 1 && out_data == held && out_label == 8'h22, "R7", "hold under stall", out_data, held);
    @(posedge clk); #1;
    drain(0);

    // R4/R5: interleaved packets on merged labels, toggling ready
    for (int k = 0; k < 12; k++) begin
      int qa, qb, la, lb;
      qa = k % 4;
      qb = (qa + 2) % 4;
      la = 1 + k % 3;
      lb = 1 + (k + 1) % 3;
      toggle_en = 1;
      for (int c = 0; c < 3; c++) begin
        if (c < la) send_cell(qa, {4'h1, k[3:0], qa[3:0], c[3:0]}, c == la - 1);
        if (c < lb) send_cell(qb, {4'h2, k[3:0], qb[3:0], c[3:0]}, c == lb - 1);
      end
      drain(1);
    end

    // R8: pool full, discard through next end-of-packet
    out_ready = 0;
    send_cell(0, 16'hC001, 0);
    send_cell(0, 16'hC002, 0);
    send_cell(0, 16'hC003, 1);
    for (int c = 0; c < 4; c++) send_cell(1, 16'hD000 + 16'(c), 0);
    send_cell(2, 16'hE001, 0);
    d0 = drop_cnt;
    send_cell(1, 16'hD0FF, 0);
    @(negedge clk);
    check(drop_cnt == d0 + 16'd1, "R8", "drop on full pool", drop_cnt, d0 + 16'd1);
    @(posedge clk); #1;
    send_cell(1, 16'hD100, 0);
    send_cell(1, 16'hD101, 1);
    @(negedge clk);
    check(drop_cnt == d0 + 16'd3, "R8", "discard through eop", drop_cnt, d0 + 16'd3);
    @(posedge clk); #1;
    send_cell(1, 16'hD200, 1);
    send_cell(2, 16'hE002, 1);
    drain(0);

    @(negedge clk);
    check(drop_cnt == 16'(drops_m), "R8", "total drops", drop_cnt, drops_m);
    check(pkt_cnt == 16'(pkts_m), "R9", "packet count", pkt_cnt, pkts_m);
    summary();
    $finish;
  end
endmodule